// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block collects interrupt sources and decides which of them reach each CPU in a small multiprocessor cluster. It holds per-source enable, trigger type, priority and CPU routing, and latches pending state. For every CPU it presents one request line and the ID of the best candidate waiting for that CPU. Software reaches the state through a simple word-addressed 32-bit register port that has a write strobe and combinational read data. Each access carries the number of the CPU that issues it.

Sources 0 to 15 are software-generated. They are always edge-like and are raised by writing the software-interrupt register. Sources 16 to 31 are private to each CPU. Their enable and pending state exist once per CPU, and the issuing CPU number selects the copy an access reaches. Input lines 16 to 31 feed every CPU's private copy. Sources 32 and above are shared, and their target field routes them. Each CPU's interface acknowledges the presented source with a one-cycle pulse.

Top module: `irq_dist`

## Requirements
- R1: After reset, these are all zero: the control register, every enable, every pending latch, every priority and every target field. Every source from 16 upward reads as level-sensitive, and no request is raised.
- R2: Word 0x10+n is the enable-set register and word 0x18+n is the enable-clear register, for n = id/32, with bit id%32 for each source. A 1 written to a set bit enables the source. A 1 written to a clear bit disables it. Zero bits change nothing. A read of either address returns the current enables.
- R3: Word 0x20+id/16 holds a 2-bit field per source at bits (id%16)*2+1 : (id%16)*2. The upper bit is 1 for edge-triggered and 0 for level-sensitive, and the lower bit reads 0. Word 0x20 (sources 0 to 15) always reads 0xAAAAAAAA, and writes to it are ignored.
- R4: Word 0x40+id/4 holds the 8-bit priority of source id in byte id%4. Word 0x80+id/4 holds its 8-bit target field in byte id%4, where bit c selects CPU c. For sources below 32, each target byte reads as the issuing CPU's bit alone, and writes to those words are ignored.
- R5: The enable and pending state of sources 0 to 31 is kept separately for each CPU, and an access reaches the copy of the CPU named on bus_cpu.
- R6: Control word 0x00 bit 0 enables forwarding. While it is 0, every irq_req is 0.
- R7: Type word 0x01 reads NSRC/32-1 in bits 4:0, with every other bit 0.
- R8: A write to word 0x02 makes source wdata[3:0] pending on every CPU c whose bit wdata[16+c] is set.
- R9: An edge source latches pending on a rising input and stays pending after the input falls. A level source is pending exactly while its input is high, and an acknowledge does not clear it.
- R10: For each CPU c, irq_req[c] is high when at least one source is enabled, pending and routed to c (sources below 32 are always routed). irq_id for c then names the candidate with the lowest priority value, and a tie goes to the lowest ID.
- R11: A pulse on irq_ack[c] while irq_req[c] is high clears the edge pending latch of the presented source. For a source below 32, the clear reaches CPU c's copy only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cpu | input | 3 | Number of the CPU issuing the register access |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| src_in | input | NSRC-16 | Source input lines for IDs 16 to NSRC-1 |
| irq_ack | input | NCPU | Per-CPU acknowledge of the presented source |
| irq_req | output | NCPU | Per-CPU interrupt request |
| irq_id | output | NCPU*ID_W | Per-CPU ID of the presented source, CPU c in bits c*ID_W+: ID_W |

## Verification
The bench writes ones and zeros to the enable-set and enable-clear words. A design that treated these as plain writes would lose bits that should survive. It writes the configuration word of the software sources and checks the read-back, which catches a design whose fixed fields can be overwritten. Equal priorities and a later priority change are used to catch a selector that prefers the higher ID or inverts the priority order. A private enable set from one CPU is checked against the other CPU, and a software interrupt is aimed at a single CPU, which exposes lost banking. An edge pulse that must outlive its input, and a level source that an acknowledge must not clear, separate the two trigger modes.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 6;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_EN, SEL_CFG, SEL_PRIO, SEL_TGT
  } regSel_e;

  typedef struct packed {
    logic             ctrlWr;
    logic             sgiWr;
    logic             enSetWr;
    logic             enClrWr;
    logic             cfgWr;
    logic             prioWr;
    logic             tgtWr;
    regSel_e          rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output strobe_t           stb
);
  localparam int EN_W   = NSRC / 32;
  localparam int CFG_W  = NSRC / 16;
  localparam int BYTE_W = NSRC / 4;

  logic [IDX_W-1:0] off;

  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    off = '0;
    if (bus_addr == 8'h00) begin
      stb.rdSel  = SEL_CTRL;
      stb.ctrlWr = bus_we;
    end else if (bus_addr == 8'h01) begin
      stb.rdSel = SEL_TYPE;
    end else if (bus_addr == 8'h02) begin
      stb.sgiWr = bus_we;
    end else if (bus_addr[7:4] == 4'h1) begin
      off = {3'b000, bus_addr[2:0]};
      if (int'(off) < EN_W) begin
        stb.idx     = off;
        stb.rdSel   = SEL_EN;
        stb.enSetWr = bus_we & ~bus_addr[3];
        stb.enClrWr = bus_we & bus_addr[3];
      end
    end else if (bus_addr[7:4] == 4'h2) begin
      off = {2'b00, bus_addr[3:0]};
      if (int'(off) < CFG_W) begin
        stb.idx   = off;
        stb.rdSel = SEL_CFG;
        stb.cfgWr = bus_we;
      end
    end else if (bus_addr[7:6] == 2'b01) begin
      off = bus_addr[5:0];
      if (int'(off) < BYTE_W) begin
        stb.idx    = off;
        stb.rdSel  = SEL_PRIO;
        stb.prioWr = bus_we;
      end
    end else if (bus_addr[7:6] == 2'b10) begin
      off = bus_addr[5:0];
      if (int'(off) < BYTE_W) begin
        stb.idx   = off;
        stb.rdSel = SEL_TGT;
        stb.tgtWr = bus_we;
      end
    end
  end
endmodule

// File: rtl/irq_dist_data.sv
module irq_dist_data
  import irq_dist_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 2,
  parameter int ID_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [2:0]           bus_cpu,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NSRC-1:16]     src_in,
  input  logic [NCPU-1:0]      irq_ack,
  output logic [NCPU-1:0]      irq_req,
  output logic [NCPU*ID_W-1:0] irq_id
);
  localparam int NSH    = NSRC - 32;
  localparam int EN_W   = NSRC / 32;
  localparam int CFG_W  = NSRC / 16;
  localparam int BYTE_W = NSRC / 4;

  logic                        ctrlEn;
  logic [NCPU-1:0][31:0]       enBank, pendBank;
  logic [NSH-1:0]              enSh, pendSh;
  logic [NSRC-17:0]            cfgStore;
  logic [NSRC-1:0][7:0]        prio;
  logic [NSH-1:0][7:0]         tgt;
  logic [NSRC-1:16]            srcPrev, rise;
  logic [NSRC-1:0]             edgeAll;
  logic [NCPU-1:0][NSRC-1:0]   enAll, pendAll, routeOk;
  logic [NCPU-1:0][ID_W-1:0]   selId;
  logic [NCPU-1:0]             selHit;

  assign edgeAll = {cfgStore, 16'hFFFF};
  assign rise    = src_in & ~srcPrev;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [31:0]    pendBankEff;
    logic [NSH-1:0] pendShEff, tgtCol;
    for (genvar i = 0; i < 32; i++) begin : g_bank
      if (i < 16) begin : g_sgi
        assign pendBankEff[i] = pendBank[c][i];
      end else begin : g_ppi
        assign pendBankEff[i] = edgeAll[i] ? pendBank[c][i] : src_in[i];
      end
    end
    for (genvar j = 0; j < NSH; j++) begin : g_sh
      assign pendShEff[j] = edgeAll[j+32] ? pendSh[j] : src_in[j+32];
      assign tgtCol[j]    = tgt[j][c];
    end
    assign enAll[c]   = {enSh, enBank[c]};
    assign pendAll[c] = {pendShEff, pendBankEff};
    assign routeOk[c] = {tgtCol, 32'hFFFF_FFFF};
    assign irq_req[c] = selHit[c];
    assign irq_id[c*ID_W +: ID_W] = selId[c];
  end

  // Per-CPU selection: lowest priority value wins, ascending scan keeps lowest ID on ties
  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      logic [7:0] bestP;
      bestP    = 8'hFF;
      selHit[c] = 1'b0;
      selId[c]  = '0;
      for (int i = 0; i < NSRC; i++) begin
        if (ctrlEn && enAll[c][i] && pendAll[c][i] && routeOk[c][i] &&
            (!selHit[c] || prio[i] < bestP)) begin
          selHit[c] = 1'b1;
          selId[c]  = ID_W'(i);
          bestP     = prio[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlEn   <= 1'b0;
      enBank   <= '0;
      pendBank <= '0;
      enSh     <= '0;
      pendSh   <= '0;
      cfgStore <= '0;
      prio     <= '0;
      tgt      <= '0;
      srcPrev  <= '0;
    end else begin
      srcPrev <= src_in;
      if (stb.ctrlWr) ctrlEn <= bus_wdata[0];
      for (int c = 0; c < NCPU; c++) begin
        if (bus_cpu == 3'(c) && stb.idx == '0) begin
          if (stb.enSetWr) enBank[c] <= enBank[c] | bus_wdata;
          if (stb.enClrWr) enBank[c] <= enBank[c] & ~bus_wdata;
        end
      end
      for (int w = 1; w < EN_W; w++) begin
        if (stb.idx == IDX_W'(w)) begin
          if (stb.enSetWr) enSh[(w-1)*32 +: 32] <= enSh[(w-1)*32 +: 32] | bus_wdata;
          if (stb.enClrWr) enSh[(w-1)*32 +: 32] <= enSh[(w-1)*32 +: 32] & ~bus_wdata;
        end
      end
      for (int w = 1; w < CFG_W; w++) begin
        if (stb.cfgWr && stb.idx == IDX_W'(w)) begin
          for (int k = 0; k < 16; k++) cfgStore[(w-1)*16+k] <= bus_wdata[2*k+1];
        end
      end
      for (int w = 0; w < BYTE_W; w++) begin
        if (stb.prioWr && stb.idx == IDX_W'(w)) begin
          for (int k = 0; k < 4; k++) prio[4*w+k] <= bus_wdata[8*k +: 8];
        end
        if (w >= 8 && stb.tgtWr && stb.idx == IDX_W'(w)) begin
          for (int k = 0; k < 4; k++) tgt[4*w+k-32] <= bus_wdata[8*k +: 8];
        end
      end
      // pending latches: set first, acknowledge clears last
      for (int c = 0; c < NCPU; c++) begin
        for (int i = 0; i < 16; i++) begin
          if (stb.sgiWr && bus_wdata[16+c] && bus_wdata[3:0] == 4'(i)) pendBank[c][i] <= 1'b1;
        end
        for (int i = 16; i < 32; i++) begin
          if (!edgeAll[i]) pendBank[c][i] <= 1'b0;
          else if (rise[i]) pendBank[c][i] <= 1'b1;
        end
      end
      for (int j = 0; j < NSH; j++) begin
        if (!edgeAll[j+32]) pendSh[j] <= 1'b0;
        else if (rise[j+32]) pendSh[j] <= 1'b1;
      end
      for (int c = 0; c < NCPU; c++) begin
        if (irq_ack[c] && selHit[c]) begin
          for (int i = 0; i < 32; i++)
            if (selId[c] == ID_W'(i)) pendBank[c][i] <= 1'b0;
          for (int j = 0; j < NSH; j++)
            if (selId[c] == ID_W'(j+32)) pendSh[j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (stb.rdSel)
      SEL_CTRL: bus_rdata = {31'b0, ctrlEn};
      SEL_TYPE: bus_rdata = {27'b0, 5'(EN_W - 1)};
      SEL_EN: begin
        for (int c = 0; c < NCPU; c++)
          if (stb.idx == '0 && bus_cpu == 3'(c)) bus_rdata = enBank[c];
        for (int w = 1; w < EN_W; w++)
          if (stb.idx == IDX_W'(w)) bus_rdata = enSh[(w-1)*32 +: 32];
      end
      SEL_CFG: begin
        for (int w = 0; w < CFG_W; w++)
          if (stb.idx == IDX_W'(w))
            for (int k = 0; k < 16; k++) bus_rdata[2*k+1] = edgeAll[16*w+k];
      end
      SEL_PRIO: begin
        for (int w = 0; w < BYTE_W; w++)
          if (stb.idx == IDX_W'(w))
            for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = prio[4*w+k];
      end
      SEL_TGT: begin
        for (int w = 0; w < BYTE_W; w++)
          if (stb.idx == IDX_W'(w))
            for (int k = 0; k < 4; k++)
              if (w < 8) bus_rdata[8*k +: 8] = 8'(1) << bus_cpu;
              else       bus_rdata[8*k +: 8] = tgt[4*w+k-32];
      end
      default: bus_rdata = '0;
    endcase
  end

  a_r6_no_fwd_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEn |-> irq_req == '0);
  a_r2_set_takes_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.enSetWr && stb.idx == IDX_W'(1)) |=> ((enSh[31:0] & $past(bus_wdata)) == $past(bus_wdata)));
  a_r2_clr_takes_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.enClrWr && stb.idx == IDX_W'(1)) |=> ((enSh[31:0] & $past(bus_wdata)) == 32'h0));
  a_r8_sgi_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.sgiWr && bus_wdata[16] && !irq_ack[0]) |=> pendBank[0][$past(bus_wdata[3:0])]);
  a_r9_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!edgeAll[NSRC-1] && !src_in[NSRC-1]) |-> !pendAll[0][NSRC-1]);
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 2,
  parameter int ID_W = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           bus_cpu,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NSRC-1:16]     src_in,
  input  logic [NCPU-1:0]      irq_ack,
  output logic [NCPU-1:0]      irq_req,
  output logic [NCPU*ID_W-1:0] irq_id
);
  strobe_t stb;

  irq_dist_ctrl #(.NSRC(NSRC)) u_ctrl (
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .stb     (stb)
  );

  irq_dist_data #(.NSRC(NSRC), .NCPU(NCPU), .ID_W(ID_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .bus_cpu  (bus_cpu),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_in   (src_in),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .irq_id   (irq_id)
  );
endmodule

// File: tb/irq_dist_tb.sv
module irq_dist_tb;
  localparam int NSRC = 64;
  localparam int NCPU = 2;
  localparam int ID_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        bus_cpu = '0;
  logic              bus_we = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NSRC-1:16]  src_in = '0;
  logic [NCPU-1:0]   irq_ack = '0;
  logic [NCPU-1:0]   irq_req;
  logic [NCPU*ID_W-1:0] irq_id;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_dist #(.NSRC(NSRC), .NCPU(NCPU)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] cpu, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] cpu, logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ack(int c);
    @(negedge clk); irq_ack[c] = 1'b1;
    @(posedge clk); #1 irq_ack[c] = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] idOf(int c);
    return 32'(irq_id[c*ID_W +: ID_W]);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 8'h00, d); check("R1 ctrl", d, 0);
    rd(0, 8'h10, d); check("R1 enable bank", d, 0);
    rd(0, 8'h11, d); check("R1 enable shared", d, 0);
    rd(0, 8'h21, d); check("R1 cfg level", d, 0);
    rd(0, 8'h48, d); check("R1 prio", d, 0);
    check("R1 no req", 32'(irq_req), 0);
    rd(0, 8'h01, d); check("R7 type", d, 32'd1);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(0, 8'h11, 32'h0000_00F0);
    rd(0, 8'h11, d); check("R2 set", d, 32'h0000_00F0);
    wr(0, 8'h11, 32'h0000_0001);
    rd(0, 8'h11, d); check("R2 set keeps", d, 32'h0000_00F1);
    wr(0, 8'h19, 32'h0000_0030);
    rd(0, 8'h11, d); check("R2 clear", d, 32'h0000_00C1);
    rd(1, 8'h19, d); check("R2 read clr addr", d, 32'h0000_00C1);
  endtask

  task automatic t_config();
    logic [31:0] d;
    wr(0, 8'h20, 32'h0000_0000);
    rd(0, 8'h20, d); check("R3 sgi cfg fixed", d, 32'hAAAA_AAAA);
    wr(0, 8'h22, 32'hFFFF_FFFF);
    rd(0, 8'h22, d); check("R3 low bit reads 0", d, 32'hAAAA_AAAA);
    wr(0, 8'h22, 32'h0);
  endtask

  task automatic t_prio_tgt();
    logic [31:0] d;
    wr(0, 8'h48, 32'h4433_2211);
    rd(0, 8'h48, d); check("R4 prio", d, 32'h4433_2211);
    wr(0, 8'h88, 32'h0201_0301);
    rd(0, 8'h88, d); check("R4 tgt", d, 32'h0201_0301);
    wr(1, 8'h80, 32'hFFFF_FFFF);
    rd(1, 8'h80, d); check("R4 banked tgt cpu1", d, 32'h0202_0202);
    rd(0, 8'h80, d); check("R4 banked tgt cpu0", d, 32'h0101_0101);
  endtask

  task automatic t_level();
    wr(0, 8'h4A, 32'h0000_2020);
    wr(0, 8'h8A, 32'h0000_0101);
    wr(0, 8'h11, 32'h0000_0300);
    @(negedge clk); src_in[40] = 1'b1;
    @(negedge clk);
    check("R6 off blocks req", 32'(irq_req), 0);
    wr(0, 8'h00, 32'h1);
    @(negedge clk);
    check("R10 level req cpu0", 32'(irq_req), 32'b01);
    check("R10 level id", idOf(0), 40);
    ack(0);
    check("R9 level ack no effect", 32'(irq_req[0]), 1);
    src_in[40] = 1'b0;
    #1 check("R9 level follows input", 32'(irq_req[0]), 0);
  endtask

  task automatic t_edge();
    wr(0, 8'h22, 32'h0008_0000);
    @(negedge clk); src_in[41] = 1'b1;
    @(negedge clk); src_in[41] = 1'b0;
    @(negedge clk);
    check("R9 edge held", 32'(irq_req[0]), 1);
    check("R9 edge id", idOf(0), 41);
    ack(0);
    check("R11 ack clears edge", 32'(irq_req[0]), 0);
  endtask

  task automatic t_priority();
    wr(0, 8'h4A, 32'h1010_2020);
    wr(0, 8'h8A, 32'h0101_0101);
    wr(0, 8'h11, 32'h0000_0F00);
    @(negedge clk); src_in[40] = 1; src_in[42] = 1; src_in[43] = 1;
    @(negedge clk);
    check("R10 tie lowest id", idOf(0), 42);
    check("R10 cpu1 not targeted", 32'(irq_req[1]), 0);
    wr(0, 8'h4A, 32'h0810_2020);
    @(negedge clk);
    check("R10 lower value wins", idOf(0), 43);
    src_in = '0;
  endtask

  task automatic t_banked();
    logic [31:0] d;
    wr(0, 8'h02, 32'h0002_0005);
    wr(1, 8'h10, 32'h0000_0020);
    rd(0, 8'h10, d); check("R5 cpu0 bank untouched", d, 0);
    rd(1, 8'h10, d); check("R5 cpu1 bank", d, 32'h20);
    @(negedge clk);
    check("R8 sgi cpu1 req", 32'(irq_req), 32'b10);
    check("R8 sgi id", idOf(1), 5);
    ack(1);
    check("R11 ack clears sgi", 32'(irq_req[1]), 0);
    wr(0, 8'h02, 32'h0001_0005);
    wr(0, 8'h10, 32'h0000_0020);
    @(negedge clk);
    check("R8 sgi cpu0 only", 32'(irq_req), 32'b01);
    check("R8 sgi cpu0 id", idOf(0), 5);
    wr(0, 8'h00, 32'h0);
    @(negedge clk);
    check("R6 off again", 32'(irq_req), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_enable();
    t_config();
    t_prio_tgt();
    t_level();
    t_edge();
    t_priority();
    t_banked();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule